// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Guard

This unit sits inside the bit engine of an I2C master and watches for lost bus arbitration. The bus lines come in raw and pass through a synchronizer. Once per SCL high phase the bit engine raises a strobe, and at that strobe the unit compares the synchronized SDA level with the bit this master wants on the line. If the master is releasing SDA to let it float high but the line reads low, another master has won. The unit then withdraws its data output enable, raises a one-cycle loss pulse and sets a sticky flag. It also asserts a keep-clocking flag, which tells the SCL generator to finish the byte that is in flight.

A bit counter, reset at each START, counts SCL clocks in groups of nine: eight data bits and the acknowledge bit. On the strobe that closes the ninth clock, the unit drops keep-clocking and returns to its idle, owning state. It does not send a STOP.

Comparison stays live for every byte of a transfer, so arbitration can run into the data bytes. The exception is high-speed mode. There every master sends a unique master code, so arbitration must be settled within the code byte. A mismatch seen after that byte is reported on a separate protocol-error output and is not treated as a loss.

Top module: `i2c_arb_guard`

## Requirements
- R1: After a synchronous reset, sda_oe is 1, and keep_clk, arb_lost, lost_sticky and hs_err are 0.
- R2: A loss is detected when all of these hold on the cycle where scl_hi_stb is 1: the synchronized SCL is high, drive_phase is 1, sda_want is 1 and the synchronized SDA is 0. SCL and SDA each pass through a two-flop synchronizer. The response shows on the outputs one clock after the strobe cycle.
- R3: No loss or error results if any of these holds: sda_want is 0, drive_phase is 0, the synchronized SCL is low, the synchronized SDA is 1, or scl_hi_stb is 0.
- R4: On a loss, sda_oe goes to 0 and keep_clk goes to 1. arb_lost is 1 for exactly one clock.
- R5: lost_sticky is set by a loss and stays set until clr_sticky is 1. If a loss and clr_sticky fall in the same cycle, the set wins.
- R6: While keep_clk is 1, further mismatches produce no new arb_lost pulse.
- R7: The bit counter advances on each bit_stb and wraps after nine counts, so index 8 is the acknowledge clock. After a loss, keep_clk stays 1 until the bit_stb taken at index 8. One clock after that strobe, keep_clk is 0 and sda_oe is 1 again.
- R8: When hs_mode is 0, a loss is detected whether code_phase is 0 or 1, so arbitration extends into data bytes.
- R9: When hs_mode is 1 and code_phase is 1, a mismatch is handled as a normal loss.
- R10: When hs_mode is 1 and code_phase is 0, a mismatch gives a one-clock hs_err pulse. It gives no arb_lost, and sda_oe stays 1.
- R11: byte_rst returns the bit counter to index 0, which restarts the count of nine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_hi_stb | input | 1 | One-cycle strobe in the middle of each SCL high phase |
| bit_stb | input | 1 | One-cycle strobe when an SCL clock completes |
| byte_rst | input | 1 | Restart the bit count (START seen) |
| sda_want | input | 1 | Bit this master intends on SDA (1 = release high) |
| drive_phase | input | 1 | 1 while this master transmits the current bit |
| hs_mode | input | 1 | High-speed transfer in progress |
| code_phase | input | 1 | 1 during the master-code byte |
| clr_sticky | input | 1 | Clear the sticky loss flag |
| sda_oe | output | 1 | Permission to drive SDA |
| keep_clk | output | 1 | Continue SCL clocking to the byte end |
| arb_lost | output | 1 | One-cycle arbitration-loss pulse |
| lost_sticky | output | 1 | Sticky arbitration-loss flag |
| hs_err | output | 1 | One-cycle high-speed protocol error pulse |

## Verification
Two functions can meet in one clock: setting the sticky loss flag and clearing it. The bench raises clr_sticky on the same cycle as a mismatching high-phase strobe. It then expects lost_sticky to read 1, because setting takes priority over clearing. A separate clear on an idle cycle must bring the flag to 0, which shows that the clear path works and that the earlier result came from priority and not from a clear that does nothing.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic {
    ARB_OWN  = 1'b0,
    ARB_LOST = 1'b1
  } arb_state_e;
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  // Idle I2C lines are high, so every stage resets to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_arb_bitcnt.sv
module i2c_arb_bitcnt #(
  parameter int BITS_PER_BYTE = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_rst,
  input  logic bit_stb,
  output logic byte_end
);
  localparam int CNT_W = $clog2(BITS_PER_BYTE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_BYTE - 1);

  logic [CNT_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || byte_rst) idx <= '0;
    else if (bit_stb) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  assign byte_end = bit_stb && !byte_rst && (idx == LAST);

  // R11 / R7: index never leaves the nine-clock range
  a_r7_idx_range: assert property (@(posedge clk) disable iff (rst) idx <= LAST);
  // R11: restart always lands on index zero
  a_r11_restart: assert property (@(posedge clk) disable iff (rst) byte_rst |=> idx == '0);
endmodule

// File: rtl/i2c_arb_core.sv
module i2c_arb_core
  import i2c_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb_valid,
  input  logic sda_s,
  input  logic drive_phase,
  input  logic sda_want,
  input  logic hs_mode,
  input  logic code_phase,
  input  logic byte_end,
  input  logic clr_sticky,
  output logic sda_oe,
  output logic keep_clk,
  output logic arb_lost,
  output logic lost_sticky,
  output logic hs_err
);
  arb_state_e st, st_nx;
  logic mism, hs_data, take_loss, flag_err;

  always_comb begin
    mism      = stb_valid && drive_phase && sda_want && !sda_s;
    hs_data   = hs_mode && !code_phase;
    take_loss = (st == ARB_OWN) && mism && !hs_data;
    flag_err  = (st == ARB_OWN) && mism && hs_data;
    st_nx     = st;
    unique case (st)
      ARB_OWN:  if (take_loss) st_nx = ARB_LOST;
      ARB_LOST: if (byte_end)  st_nx = ARB_OWN;
      default:  st_nx = ARB_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ARB_OWN;
      sda_oe      <= 1'b1;
      keep_clk    <= 1'b0;
      arb_lost    <= 1'b0;
      hs_err      <= 1'b0;
      lost_sticky <= 1'b0;
    end else begin
      st          <= st_nx;
      sda_oe      <= (st_nx == ARB_OWN);
      keep_clk    <= (st_nx == ARB_LOST);
      arb_lost    <= take_loss;
      hs_err      <= flag_err;
      lost_sticky <= take_loss || (lost_sticky && !clr_sticky);
    end
  end

  // R4: loss pulse lasts one clock and comes with released data and clocking on
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst) arb_lost |=> !arb_lost);
  a_r4_release: assert property (@(posedge clk) disable iff (rst) arb_lost |-> (!sda_oe && keep_clk));
  // R5: sticky flag follows a loss and holds without a clear
  a_r5_sticky_set: assert property (@(posedge clk) disable iff (rst) arb_lost |-> lost_sticky);
  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (lost_sticky && !clr_sticky) |=> lost_sticky);
  // R6: no second loss while finishing the byte
  a_r6_no_relose: assert property (@(posedge clk) disable iff (rst) keep_clk |=> !arb_lost);
  // R7: clocking continues until the byte-end strobe
  a_r7_hold_clk: assert property (@(posedge clk) disable iff (rst)
    (keep_clk && !byte_end) |=> keep_clk);
  // R10: protocol error and loss never coincide; error leaves output enabled
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst) !(hs_err && arb_lost));
  a_r10_oe_kept: assert property (@(posedge clk) disable iff (rst) hs_err |-> sda_oe);
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard #(
  parameter int BITS_PER_BYTE = 9,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic scl_hi_stb,
  input  logic bit_stb,
  input  logic byte_rst,
  input  logic sda_want,
  input  logic drive_phase,
  input  logic hs_mode,
  input  logic code_phase,
  input  logic clr_sticky,
  output logic sda_oe,
  output logic keep_clk,
  output logic arb_lost,
  output logic lost_sticky,
  output logic hs_err
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s;
  logic scl_s, sda_s, byte_end, stb_valid;

  i2c_arb_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(line_s)
  );

  assign scl_s     = line_s[1];
  assign sda_s     = line_s[0];
  assign stb_valid = scl_hi_stb && scl_s;

  i2c_arb_bitcnt #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_cnt (
    .clk(clk), .rst(rst), .byte_rst(byte_rst), .bit_stb(bit_stb), .byte_end(byte_end)
  );

  i2c_arb_core u_core (
    .clk(clk), .rst(rst), .stb_valid(stb_valid), .sda_s(sda_s),
    .drive_phase(drive_phase), .sda_want(sda_want), .hs_mode(hs_mode),
    .code_phase(code_phase), .byte_end(byte_end), .clr_sticky(clr_sticky),
    .sda_oe(sda_oe), .keep_clk(keep_clk), .arb_lost(arb_lost),
    .lost_sticky(lost_sticky), .hs_err(hs_err)
  );

  // R3: without a valid strobe no loss can appear on the next clock
  a_r3_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !stb_valid |=> !arb_lost);
endmodule

// File: tb/sim_i2c_arb_guard.sv
module sim_i2c_arb_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1, sda_in = 1'b1, scl_hi_stb = 1'b0, bit_stb = 1'b0, byte_rst = 1'b0;
  logic sda_want = 1'b1, drive_phase = 1'b0, hs_mode = 1'b0, code_phase = 1'b0, clr_sticky = 1'b0;
  logic sda_oe, keep_clk, arb_lost, lost_sticky, hs_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  i2c_arb_guard u0 (.*);

  // bits: hs code drive want sda scl | exp_lost exp_err
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    8'b0011_0110,  // R2 R8: data-phase mismatch, normal mode
    8'b0010_0100,  // R3: master drives 0
    8'b0001_0100,  // R3: receive phase
    8'b0011_0000,  // R3: SCL low
    8'b0011_1100,  // R3: line agrees
    8'b1111_0110,  // R9: HS master-code mismatch
    8'b1011_0101,  // R10: HS data-phase mismatch
    8'b1011_1100   // R10: HS data phase, no mismatch
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; scl_in = 1'b1; sda_in = 1'b1; scl_hi_stb = 1'b0; bit_stb = 1'b0;
    byte_rst = 1'b0; sda_want = 1'b1; drive_phase = 1'b0; hs_mode = 1'b0;
    code_phase = 1'b0; clr_sticky = 1'b0;
    tick(); tick(); rst = 1'b0; tick();
  endtask

  task automatic lines(logic hs, logic code, logic drv, logic want, logic sda, logic scl);
    hs_mode = hs; code_phase = code; drive_phase = drv; sda_want = want;
    sda_in = sda; scl_in = scl;
    repeat (3) tick();
  endtask

  task automatic fire(); scl_hi_stb = 1'b1; tick(); scl_hi_stb = 1'b0; endtask
  task automatic bit_pulse(); bit_stb = 1'b1; tick(); bit_stb = 1'b0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 sda_oe", sda_oe, 1'b1);
    chk("R1 keep_clk", keep_clk, 1'b0);
    chk("R1 arb_lost", arb_lost, 1'b0);
    chk("R1 sticky", lost_sticky, 1'b0);
    chk("R1 hs_err", hs_err, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      lines(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      fire();
      chk($sformatf("R2 vec%0d arb_lost", i), arb_lost, VEC[i][1]);
      chk($sformatf("R10 vec%0d hs_err", i), hs_err, VEC[i][0]);
      chk($sformatf("R4 vec%0d sda_oe", i), sda_oe, !VEC[i][1]);
      tick();
      chk($sformatf("R4 vec%0d pulse end", i), arb_lost, 1'b0);
      chk($sformatf("R10 vec%0d err end", i), hs_err, 1'b0);
    end

    // R3: mismatch on the line but no strobe
    do_reset();
    lines(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (5) tick();
    chk("R3 no strobe", arb_lost | lost_sticky, 1'b0);

    // R8: normal mode, code phase also arbitrates
    do_reset();
    lines(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    fire();
    chk("R8 code phase loss", arb_lost, 1'b1);

    // R7 R6 R5: loss at index 3, finish byte
    do_reset();
    byte_rst = 1'b1; tick(); byte_rst = 1'b0;
    repeat (3) bit_pulse();
    lines(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    fire();
    chk("R4 lost", arb_lost, 1'b1);
    chk("R4 keep_clk", keep_clk, 1'b1);
    tick();
    fire();
    chk("R6 no relose", arb_lost, 1'b0);
    for (int k = 0; k < 5; k++) begin
      bit_pulse();
      chk("R7 still clocking", keep_clk, 1'b1);
      chk("R7 oe off", sda_oe, 1'b0);
    end
    bit_pulse();
    chk("R7 keep_clk dropped", keep_clk, 1'b0);
    chk("R7 oe back", sda_oe, 1'b1);
    chk("R5 sticky held", lost_sticky, 1'b1);
    clr_sticky = 1'b1; tick(); clr_sticky = 1'b0;
    chk("R5 sticky cleared", lost_sticky, 1'b0);

    // R5: set and clear in the same cycle, set wins
    clr_sticky = 1'b1; fire(); clr_sticky = 1'b0;
    chk("R5 set wins", lost_sticky, 1'b1);

    // R11: restart mid-byte
    do_reset();
    repeat (4) bit_pulse();
    byte_rst = 1'b1; tick(); byte_rst = 1'b0;
    repeat (2) bit_pulse();
    lines(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    fire();
    repeat (6) bit_pulse();
    chk("R11 count restarted", keep_clk, 1'b1);
    bit_pulse();
    chk("R11 byte end", keep_clk, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule